// File: doc/BRIEF.md
# Square-Wave Phase Accumulator Synthesizer

This block makes a digital square wave whose frequency is set by a binary tuning word. A phase accumulator of `ACC_W` bits gains the active increment on every cycle in which the update strobe `upd_i` is high. The square output is the accumulator's top bit. The output frequency is the update rate times the increment divided by 2^ACC_W. With a 50 kHz update rate and 32 bits, one increment step is roughly 12 µHz. The update rate has to exceed twice the highest output frequency that is wanted. Over time the duty cycle averages to one half.

The tuning word is shifted in serially, most significant bit first, into a shift chain of `INC_W` bits. The active increment only changes when `load_i` is pulsed. A small load-control state machine makes that transfer atomic with respect to ticks. It has two states:
- **IDLE**: a load seen in a cycle with no tick commits at once and stays in IDLE. A load that coincides with a tick moves to **DEFER**.
- **DEFER**: the first cycle without a tick commits and returns to IDLE. Further loads while in DEFER are absorbed.

A one-cycle wrap pulse marks each addition that carried out of the accumulator.

Top module: `sqwave_nco`

## Requirements
- R1: After synchronous reset `rst`, `sq_o` and `wrap_o` are 0, and the shift chain and active increment are zero, so ticks leave `sq_o` at 0 until a word is loaded.
- R2: At each rising edge with `upd_i`=1, the accumulator becomes (accumulator + active increment) mod 2^ACC_W. With `upd_i`=0 it holds. The increment is zero-extended from INC_W bits.
- R3: `sq_o` equals the accumulator's most significant bit (bit ACC_W-1). Starting from zero, N ticks with increment K produce floor(N·K / 2^ACC_W) wraps.
- R4: `wrap_o` is 1 for exactly the one cycle after a tick whose addition carried out of bit ACC_W-1, and is 0 otherwise.
- R5: At each edge with `sen_i`=1, the chain shifts left by one and `sdi_i` enters bit 0. The first of INC_W bits shifted in therefore ends in the MSB.
- R6: Shifting without a load has no effect on the active increment, and so none on `sq_o` or `wrap_o`.
- R7: A commit copies the chain contents of the commit cycle into the active increment at that edge. In IDLE, `load_i` with `upd_i`=0 commits in the same cycle. The active increment never changes at an edge that follows a tick cycle.
- R8: `load_i` together with `upd_i`=1 enters DEFER. That tick uses the old increment, and the commit happens at the first following cycle with `upd_i`=0. Loads seen while in DEFER do not add further commits.
- R9: A zero active increment keeps the accumulator, and so `sq_o`, static and `wrap_o` at 0 across ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_i | input | 1 | Update tick strobe |
| sen_i | input | 1 | Serial shift enable |
| sdi_i | input | 1 | Serial tuning data, MSB first |
| load_i | input | 1 | Transfer shift chain to active increment |
| sq_o | output | 1 | Square-wave output (accumulator MSB) |
| wrap_o | output | 1 | One-cycle accumulator carry-out pulse |

## Verification
The assertions assume that every input is a clean synchronous level, free of X, and sampled only at the rising clock edge. They also assume that reset is held from time zero through at least one edge. The bench changes all inputs on the falling edge and starts with reset asserted. Its random phase mixes ticks, shifts, serial data and loads freely, including loads coincident with ticks and shifts while a commit is deferred. All of these fall inside those assumptions. Directed phases add a known quarter-turn word, a zero word and a wrap-count run.

// File: rtl/nco_pkg.sv
package nco_pkg;
    typedef enum logic [0:0] {
        LD_IDLE  = 1'b0,
        LD_DEFER = 1'b1
    } ld_state_t;
endpackage

// File: rtl/nco_tune_shift.sv
module nco_tune_shift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sen_i,
    input  logic         sdi_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] chain_q;

    generate
        if (W == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst)        chain_q <= '0;
                else if (sen_i) chain_q <= sdi_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst)        chain_q <= '0;
                else if (sen_i) chain_q <= {chain_q[W-2:0], sdi_i};
            end
        end
    endgenerate

    assign word_o = chain_q;

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sen_i |=> $stable(word_o)); // R6
    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        sen_i |=> (word_o[0] == $past(sdi_i))); // R5
endmodule

// File: rtl/nco_load_ctrl.sv
module nco_load_ctrl
    import nco_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic upd_i,
    input  logic load_i,
    output logic commit_o
);
    ld_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= LD_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        commit_o = 1'b0;
        unique case (state_q)
            LD_IDLE: begin
                if (load_i && !upd_i) commit_o = 1'b1;
                else if (load_i)      state_d  = LD_DEFER;
            end
            LD_DEFER: begin
                if (!upd_i) begin
                    commit_o = 1'b1;
                    state_d  = LD_IDLE;
                end
            end
            default: state_d = LD_IDLE;
        endcase
    end

    AST_DEFER_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == LD_DEFER) |-> $past(upd_i && load_i)); // R8
    AST_DEFER_EXIT: assert property (@(posedge clk) disable iff (rst)
        $fell(state_q == LD_DEFER) |-> !$past(upd_i)); // R8
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_i,
    input  logic [ACC_W-1:0] inc_i,
    output logic             msb_o,
    output logic             wrap_o
);
    logic [ACC_W-1:0] acc_q;
    logic             wrap_q;
    logic [ACC_W:0]   sum;

    assign sum = {1'b0, acc_q} + {1'b0, inc_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            wrap_q <= 1'b0;
        end else if (upd_i) begin
            acc_q  <= sum[ACC_W-1:0];
            wrap_q <= sum[ACC_W];
        end else begin
            wrap_q <= 1'b0;
        end
    end

    assign msb_o  = acc_q[ACC_W-1];
    assign wrap_o = wrap_q;

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> $stable(acc_q)); // R2
    AST_WRAP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        wrap_o |-> $past(upd_i)); // R4
    AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> !wrap_o); // R4
    AST_ZERO_INC_STATIC: assert property (@(posedge clk) disable iff (rst)
        (inc_i == '0) |=> ($stable(acc_q) && !wrap_o)); // R9
endmodule

// File: rtl/sqwave_nco.sv
module sqwave_nco #(
    parameter int ACC_W = 32,
    parameter int INC_W = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic upd_i,
    input  logic sen_i,
    input  logic sdi_i,
    input  logic load_i,
    output logic sq_o,
    output logic wrap_o
);
    localparam int PAD = ACC_W - INC_W;

    logic [INC_W-1:0] chain_w;
    logic [INC_W-1:0] inc_q;
    logic [ACC_W-1:0] inc_ext;
    logic             commit;

    initial begin
        if (INC_W > ACC_W || INC_W < 1) $error("INC_W must be 1..ACC_W");
    end

    nco_tune_shift #(.W(INC_W)) u_shift (
        .clk(clk), .rst(rst), .sen_i(sen_i), .sdi_i(sdi_i), .word_o(chain_w)
    );

    nco_load_ctrl u_ld (
        .clk(clk), .rst(rst), .upd_i(upd_i), .load_i(load_i), .commit_o(commit)
    );

    always_ff @(posedge clk) begin
        if (rst)         inc_q <= '0;
        else if (commit) inc_q <= chain_w;
    end

    generate
        if (PAD == 0) begin : g_full
            assign inc_ext = inc_q;
        end else begin : g_pad
            assign inc_ext = {{PAD{1'b0}}, inc_q};
        end
    endgenerate

    nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst(rst), .upd_i(upd_i), .inc_i(inc_ext),
        .msb_o(sq_o), .wrap_o(wrap_o)
    );

    AST_INC_NOT_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        !$stable(inc_q) |-> !$past(upd_i)); // R7
    AST_INC_FROM_CHAIN: assert property (@(posedge clk) disable iff (rst)
        !$stable(inc_q) |-> (inc_q == $past(chain_w))); // R7
endmodule

// File: tb/sqwave_nco_test.sv
module sqwave_nco_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic upd = 1'b0, sen = 1'b0, sdi = 1'b0, ld = 1'b0;
    logic sq, wrap;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [31:0] m_acc, m_inc, m_sh;
    logic        m_wrap, m_pend;

    always #5 clk = ~clk;

    sqwave_nco uut (
        .clk(clk), .rst(rst), .upd_i(upd), .sen_i(sen), .sdi_i(sdi),
        .load_i(ld), .sq_o(sq), .wrap_o(wrap)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    // expected next state from the requirements
    task automatic model_edge(input logic u, input logic s, input logic d, input logic l);
        logic [32:0] sum;
        logic        commit;
        commit = 1'b0;
        if (!m_pend) begin
            if (l && !u) commit = 1'b1;
            else if (l)  m_pend = 1'b1;
        end else if (!u) begin
            commit = 1'b1;
            m_pend = 1'b0;
        end
        sum = {1'b0, m_acc} + {1'b0, m_inc};
        if (u) begin
            m_acc  = sum[31:0];
            m_wrap = sum[32];
        end else begin
            m_wrap = 1'b0;
        end
        if (commit) m_inc = m_sh;
        if (s) m_sh = {m_sh[30:0], d};
    endtask

    task automatic step(input logic u, input logic s, input logic d, input logic l,
                        input string tag);
        upd = u; sen = s; sdi = d; ld = l;
        @(posedge clk);
        model_edge(u, s, d, l);
        @(negedge clk);
        check({tag, " sq"}, sq, m_acc[31]);
        check({tag, " wrap"}, wrap, m_wrap);
    endtask

    task automatic shift_word(input logic [31:0] w, input string tag);
        for (int i = 31; i >= 0; i--) step(1'b0, 1'b1, w[i], 1'b0, tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int wraps;
        logic first;
        void'($urandom(32'h5eed_1234));
        m_acc = '0; m_inc = '0; m_sh = '0; m_wrap = 1'b0; m_pend = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset sq", sq, 1'b0);
        check("R1 reset wrap", wrap, 1'b0);
        // R1: ticks with the reset increment keep output low
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        check("R1 still low", sq, 1'b0);

        // R5 R7: quarter-turn word 0x4000_0000, load in an idle cycle
        shift_word(32'h4000_0000, "R5");
        step(1'b0, 1'b0, 1'b0, 1'b1, "R7");
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R3");
        // after 8 quarter turns: two full wraps, accumulator back to 0
        check("R3 sq after 8 ticks", sq, 1'b0);

        // R6: shift a new word without load, behaviour stays quarter-turn
        shift_word(32'hFFFF_FFFF, "R6");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R6");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R6");
        check("R6 sq half turn", sq, 1'b1);

        // R8: load coincident with a tick, extra load during defer
        step(1'b1, 1'b0, 1'b0, 1'b1, "R8");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R8");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R8");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R8");

        // R9: zero word keeps output static
        shift_word(32'h0, "R9");
        step(1'b0, 1'b0, 1'b0, 1'b1, "R9");
        first = sq;
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R9");
        check("R9 static", sq, first);

        // R3 R4: wrap count from zero with K = 0x0123_4567 over 2000 ticks
        rst = 1'b1;
        @(posedge clk);
        m_acc = '0; m_inc = '0; m_sh = '0; m_wrap = 1'b0; m_pend = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        shift_word(32'h0123_4567, "R5");
        step(1'b0, 1'b0, 1'b0, 1'b1, "R7");
        wraps = 0;
        for (int i = 0; i < 2000; i++) begin
            step(1'b1, 1'b0, 1'b0, 1'b0, "R4");
            if (wrap) wraps++;
        end
        total++;
        if (wraps != int'((64'd2000 * 64'h0123_4567) >> 32)) begin
            bad++;
            $display("FAIL R3 wraps actual=%0d expected=%0d", wraps,
                     int'((64'd2000 * 64'h0123_4567) >> 32));
        end

        // random mix: R2 R4 R5 R7 R8
        for (int i = 0; i < 20000; i++) begin
            logic u, s, d, l;
            u = ($urandom % 2) == 0;
            s = ($urandom % 3) == 0;
            d = $urandom % 2;
            l = ($urandom % 40) == 0;
            step(u, s, d, l, "R2 rand");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule